// File: doc/BRIEF.md
# Control Endpoint IN Handshake Controller

This block keeps the control and status state for the IN direction of a USB device's default control endpoint and picks the reply to every token the packet engine reports. Software talks to it through one 32-bit register that it writes with a strobe and reads back at any time. The packet engine supplies these inputs:
- IN-token and SETUP-received pulses
- a FIFO-has-data level
- a transfer-done pulse
- two global NAK levels

For every token the block returns a two-bit response code one cycle later. It also drives a transmit-enable level and two single-cycle interrupt pulses: one for endpoint disabled and one for transfer complete.

The response follows a fixed priority. A SETUP packet is always acknowledged. STALL overrides every NAK source. A NAK holds off data even when the FIFO is full. Software sets and clears NAK through two separate write-only strobe bits. The hardware itself sets NAK and clears STALL whenever a SETUP arrives. Software arms the endpoint with an enable bit. It can then ask for a disable, and the hardware retires that request. The hardware always clears enable before it raises either interrupt.

Top module: `ep0_in_ctrl`

## Requirements
- R1: After synchronous reset the register reads 32'h0000_8000, tx_enable and both interrupts are low, resp_valid is low and max_pkt_bytes is 64.
- R2: A write with bit 27 set sets the NAK state and a write with bit 26 set clears it. When both are 1 in one write, set wins. Bits 27 and 26 always read 0, and the NAK state reads at bit 17.
- R3: A setup_rcvd pulse sets NAK and clears STALL on the next edge, even if a STALL write occurs in the same cycle. One cycle later it yields resp_valid with code ACK (2'd0), and this takes precedence over an in_token in the same cycle.
- R4: A write with bit 21 set sets STALL. A write with bit 21 clear leaves STALL unchanged. STALL reads at bit 21.
- R5: An in_token (without setup_rcvd) gives resp_valid one cycle later, and the code depends on state at the token cycle:
  - STALL (2'd3) if STALL is set;
  - otherwise NAK (2'd2) if local NAK, global_np_in_nak or global_out_nak is set;
  - otherwise DATA (2'd1) if enabled and fifo_has_data;
  - otherwise NAK.
- R6: A write with bit 31 set sets enable. A write with bit 31 clear leaves it unchanged. Enable reads at bit 31 and drives tx_enable. A hardware clear wins over a same-cycle set.
- R7: A write with bit 30 set takes effect only while enable is set. A pending disable clears both bit 30 and bit 31 on the next edge, and intr_ep_disabled pulses for exactly one cycle one cycle after that.
- R8: xfer_done while enabled clears enable on the next edge, and intr_xfer_done pulses for one cycle one cycle later. xfer_done while disabled has no effect.
- R9: Bits 1:0 are a read/write size code, and max_pkt_bytes gives 64 >> code (0:64, 1:32, 2:16, 3:8).
- R10: Bits 25:22 are a read/write 4-bit FIFO number, reset to 0.
- R11: Bit 15 always reads 1, bits 19:18 always read 00, and all other undefined bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value |
| in_token | input | 1 | IN token received pulse |
| setup_rcvd | input | 1 | SETUP packet received pulse |
| fifo_has_data | input | 1 | Transmit FIFO holds data |
| xfer_done | input | 1 | Transfer finished pulse |
| global_np_in_nak | input | 1 | Global non-periodic IN NAK |
| global_out_nak | input | 1 | Global OUT NAK |
| resp_valid | output | 1 | Response code valid |
| resp_code | output | 2 | 0 ACK, 1 DATA, 2 NAK, 3 STALL |
| tx_enable | output | 1 | Endpoint enabled for transmit |
| intr_ep_disabled | output | 1 | Endpoint-disabled interrupt pulse |
| intr_xfer_done | output | 1 | Transfer-complete interrupt pulse |
| max_pkt_bytes | output | 7 | Decoded maximum packet size in bytes |

## Verification
IN tokens are issued under each priority layer in turn: STALL with every NAK source active, each global NAK alone, local NAK with a full FIFO, an enabled endpoint with and without FIFO data, and a disabled endpoint. Together these separate a wrong priority order from a missing NAK source. SETUP is driven alongside a token and alongside a STALL write, which exposes a wrong precedence between hardware and software updates. Disable requests are issued both while enabled and while disabled, and transfer-done likewise, to show that the interrupt timing and the ignore rules hold.

// File: rtl/ep0_in_pkg.sv
package ep0_in_pkg;
    localparam int REG_W  = 32;
    localparam int FNUM_W = 4;
    localparam int MPS_W  = 2;
    localparam int BYTES_W = 7;

    localparam int B_EN    = 31;
    localparam int B_DIS   = 30;
    localparam int B_SNAK  = 27;
    localparam int B_CNAK  = 26;
    localparam int B_FNUM  = 22;
    localparam int B_STALL = 21;
    localparam int B_NAK   = 17;
    localparam int B_ACT   = 15;

    typedef enum logic [1:0] {
        RESP_ACK   = 2'd0,
        RESP_DATA  = 2'd1,
        RESP_NAK   = 2'd2,
        RESP_STALL = 2'd3
    } resp_e;

    typedef struct packed {
        logic              en;
        logic              dis;
        logic              stall;
        logic              nak;
        logic [FNUM_W-1:0] fnum;
        logic [MPS_W-1:0]  mps;
    } ep_state_t;

    typedef struct packed {
        logic              set_en;
        logic              req_dis;
        logic              set_stall;
        logic              set_nak;
        logic              clr_nak;
        logic [FNUM_W-1:0] fnum;
        logic [MPS_W-1:0]  mps;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_wr(logic [REG_W-1:0] d);
        wr_cmd_t c;
        c.set_en    = d[B_EN];
        c.req_dis   = d[B_DIS];
        c.set_stall = d[B_STALL];
        c.set_nak   = d[B_SNAK];
        c.clr_nak   = d[B_CNAK];
        c.fnum      = d[B_FNUM +: FNUM_W];
        c.mps       = d[MPS_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_rd(ep_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[B_EN]                = s.en;
        r[B_DIS]               = s.dis;
        r[B_FNUM +: FNUM_W]    = s.fnum;
        r[B_STALL]             = s.stall;
        r[B_NAK]               = s.nak;
        r[B_ACT]               = 1'b1;
        r[MPS_W-1:0]           = s.mps;
        return r;
    endfunction

    function automatic logic [BYTES_W-1:0] mps_bytes(logic [MPS_W-1:0] code);
        return BYTES_W'(64) >> code;
    endfunction
endpackage

// File: rtl/ep0_reg_state.sv
module ep0_reg_state
    import ep0_in_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             setup_rcvd,
    input  logic             xfer_done,
    output ep_state_t        st,
    output logic             dis_fire,
    output logic             done_fire
);
    wr_cmd_t   cmd;
    ep_state_t nx;

    assign cmd       = decode_wr(wr_data);
    assign dis_fire  = st.dis;
    assign done_fire = st.en & xfer_done;

    always_comb begin
        nx = st;
        if (wr_en) begin
            nx.fnum = cmd.fnum;
            nx.mps  = cmd.mps;
            if (cmd.set_en)              nx.en    = 1'b1;
            if (cmd.set_stall)           nx.stall = 1'b1;
            if (cmd.req_dis && st.en)    nx.dis   = 1'b1;
            if (cmd.set_nak)             nx.nak   = 1'b1;
            else if (cmd.clr_nak)        nx.nak   = 1'b0;
        end
        if (setup_rcvd) begin
            nx.nak   = 1'b1;
            nx.stall = 1'b0;
        end
        if (dis_fire) begin
            nx.en  = 1'b0;
            nx.dis = 1'b0;
        end
        if (done_fire) nx.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    // R3
    setup_nak_chk: assert property (@(posedge clk) disable iff (rst)
        setup_rcvd |=> (st.nak && !st.stall));

    // R7
    dis_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_DIS] && !st.en) |=> !st.dis);

    // R2
    strobe_pri_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_SNAK] && wr_data[B_CNAK]) |=> st.nak);
endmodule

// File: rtl/ep0_resp_sel.sv
module ep0_resp_sel
    import ep0_in_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_token,
    input  logic      setup_rcvd,
    input  logic      fifo_has_data,
    input  logic      global_np_in_nak,
    input  logic      global_out_nak,
    input  ep_state_t st,
    output logic      resp_valid,
    output resp_e     resp_code
);
    resp_e pick;
    logic  any_nak;

    assign any_nak = st.nak | global_np_in_nak | global_out_nak;

    always_comb begin
        if (setup_rcvd)                      pick = RESP_ACK;
        else if (st.stall)                   pick = RESP_STALL;
        else if (any_nak)                    pick = RESP_NAK;
        else if (st.en && fifo_has_data)     pick = RESP_DATA;
        else                                 pick = RESP_NAK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_code  <= RESP_ACK;
        end else begin
            resp_valid <= in_token | setup_rcvd;
            resp_code  <= pick;
        end
    end

    // R5
    stall_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (in_token && !setup_rcvd && st.stall) |=> (resp_valid && resp_code == RESP_STALL));

    // R3
    setup_ack_chk: assert property (@(posedge clk) disable iff (rst)
        setup_rcvd |=> (resp_valid && resp_code == RESP_ACK));
endmodule

// File: rtl/ep0_irq_delay.sv
module ep0_irq_delay (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    logic cleared_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cleared_q <= 1'b0;
            pulse     <= 1'b0;
        end else begin
            cleared_q <= fire;
            pulse     <= cleared_q;
        end
    end

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/ep0_in_ctrl.sv
module ep0_in_ctrl
    import ep0_in_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    input  logic               in_token,
    input  logic               setup_rcvd,
    input  logic               fifo_has_data,
    input  logic               xfer_done,
    input  logic               global_np_in_nak,
    input  logic               global_out_nak,
    output logic               resp_valid,
    output logic [1:0]         resp_code,
    output logic               tx_enable,
    output logic               intr_ep_disabled,
    output logic               intr_xfer_done,
    output logic [BYTES_W-1:0] max_pkt_bytes
);
    ep_state_t        st;
    logic             dis_fire;
    logic             done_fire;
    resp_e            code_e;
    logic [N_IRQ-1:0] fires;
    logic [N_IRQ-1:0] pulses;

    ep0_reg_state u_state (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .setup_rcvd(setup_rcvd), .xfer_done(xfer_done),
        .st(st), .dis_fire(dis_fire), .done_fire(done_fire)
    );

    ep0_resp_sel u_resp (
        .clk(clk), .rst(rst), .in_token(in_token), .setup_rcvd(setup_rcvd),
        .fifo_has_data(fifo_has_data), .global_np_in_nak(global_np_in_nak),
        .global_out_nak(global_out_nak), .st(st),
        .resp_valid(resp_valid), .resp_code(code_e)
    );

    assign fires = {done_fire, dis_fire};

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        ep0_irq_delay u_irq (.clk(clk), .rst(rst), .fire(fires[i]), .pulse(pulses[i]));
    end

    assign resp_code        = code_e;
    assign reg_rd_data      = pack_rd(st);
    assign tx_enable        = st.en;
    assign intr_ep_disabled = pulses[0];
    assign intr_xfer_done   = pulses[N_IRQ-1];
    assign max_pkt_bytes    = mps_bytes(st.mps);

    // R8
    en_clear_first_chk: assert property (@(posedge clk) disable iff (rst)
        intr_xfer_done |-> $past(!tx_enable));

    // R7
    dis_clear_first_chk: assert property (@(posedge clk) disable iff (rst)
        intr_ep_disabled |-> $past(!tx_enable && !reg_rd_data[B_DIS]));
endmodule

// File: tb/ep0_in_ctrl_tb.sv
module ep0_in_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        tok = 1'b0, setup = 1'b0, fifo = 1'b0, done = 1'b0, gnp = 1'b0, gout = 1'b0;
    logic        rv, txe, idis, idone;
    logic [1:0]  rc;
    logic [6:0]  mpb;

    int checks = 0;
    int fails  = 0;
    int wd_cnt = 0;

    always #2.5 clk = ~clk;

    ep0_in_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_wr_data(wd), .reg_rd_data(rd),
        .in_token(tok), .setup_rcvd(setup), .fifo_has_data(fifo), .xfer_done(done),
        .global_np_in_nak(gnp), .global_out_nak(gout),
        .resp_valid(rv), .resp_code(rc), .tx_enable(txe),
        .intr_ep_disabled(idis), .intr_xfer_done(idone), .max_pkt_bytes(mpb)
    );

    // behavioural reference model
    int m_en, m_dis, m_stall, m_nak, m_fnum, m_mps;
    int m_rv, m_rc, m_dq, m_di, m_xq, m_xi;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_dis = 0; m_stall = 0; m_nak = 0; m_fnum = 0; m_mps = 0;
            m_rv = 0; m_rc = 0; m_dq = 0; m_di = 0; m_xq = 0; m_xi = 0;
        end else begin
            int dfire, xfire;
            dfire = m_dis;
            xfire = (m_en != 0 && done) ? 1 : 0;
            m_rv = (tok || setup) ? 1 : 0;
            if (setup) m_rc = 0;
            else if (m_stall != 0) m_rc = 3;
            else if (m_nak != 0 || gnp || gout) m_rc = 2;
            else if (m_en != 0 && fifo) m_rc = 1;
            else m_rc = 2;
            m_di = m_dq; m_dq = dfire;
            m_xi = m_xq; m_xq = xfire;
            if (wr) begin
                m_fnum = int'(wd[25:22]);
                m_mps  = int'(wd[1:0]);
                if (wd[31]) m_en = 1;
                if (wd[21]) m_stall = 1;
                if (wd[30] && m_en != 0 && dfire == 0) m_dis = 1;
                if (wd[27]) m_nak = 1; else if (wd[26]) m_nak = 0;
            end
            if (setup) begin m_nak = 1; m_stall = 0; end
            if (dfire != 0) begin m_en = 0; m_dis = 0; end
            if (xfire != 0) m_en = 0;
        end
    end

    function automatic logic [31:0] model_rd();
        logic [31:0] r = 32'h0000_8000;
        r[31] = m_en[0]; r[30] = m_dis[0]; r[25:22] = m_fnum[3:0];
        r[21] = m_stall[0]; r[17] = m_nak[0]; r[1:0] = m_mps[1:0];
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(rd == model_rd(), "R11 register image", rd, model_rd());
            check(rv == m_rv[0], "R5 resp_valid", 32'(rv), 32'(m_rv));
            if (m_rv != 0) check(rc == m_rc[1:0], "R5 resp_code", 32'(rc), 32'(m_rc));
            check(txe == m_en[0], "R6 tx_enable", 32'(txe), 32'(m_en));
            check(idis == m_di[0], "R7 intr_ep_disabled", 32'(idis), 32'(m_di));
            check(idone == m_xi[0], "R8 intr_xfer_done", 32'(idone), 32'(m_xi));
            check(mpb == 7'(64 >> m_mps), "R9 max_pkt_bytes", 32'(mpb), 32'(64 >> m_mps));
        end
    end

    task automatic step(input logic w, input logic [31:0] d, input logic t, input logic s,
                        input logic f, input logic x, input logic gn, input logic go);
        wr = w; wd = d; tok = t; setup = s; fifo = f; done = x; gnp = gn; gout = go;
        @(posedge clk); #2;
        wr = 0; tok = 0; setup = 0; done = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, fifo, 0, gnp, gout);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 5000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        check(rd == 32'h0000_8000, "R1 reset read", rd, 32'h0000_8000);
        check(!txe && !idis && !idone && !rv, "R1 outputs low", {rv, txe, idis, idone}, 0);
        check(mpb == 7'd64, "R1 size", 32'(mpb), 64);

        // R9 R10 field writes
        step(1, 32'h0240_0003, 0, 0, 0, 0, 0, 0);
        check(mpb == 7'd8, "R9 code 3", 32'(mpb), 8);
        check(rd[25:22] == 4'h9, "R10 fifo number", 32'(rd[25:22]), 9);
        step(1, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        check(mpb == 7'd32, "R9 code 1", 32'(mpb), 32);
        step(1, 32'h0000_0002, 0, 0, 0, 0, 0, 0);
        check(mpb == 7'd16, "R9 code 2", 32'(mpb), 16);

        // R2 strobes
        step(1, 32'h0800_0000, 0, 0, 0, 0, 0, 0);
        check(rd[17] && !rd[27] && !rd[26], "R2 set nak", rd, 32'h0002_8000);
        step(1, 32'h0400_0000, 0, 0, 0, 0, 0, 0);
        check(!rd[17], "R2 clear nak", rd, 32'h0000_8000);
        step(1, 32'h0C00_0000, 0, 0, 0, 0, 0, 0);
        check(rd[17], "R2 set wins", rd, 32'h0002_8000);
        step(1, 32'h0400_0000, 0, 0, 0, 0, 0, 0);

        // R5 disabled endpoint with data -> NAK
        step(0, 0, 1, 0, 1, 0, 0, 0);
        check(rv && rc == 2'd2, "R5 not enabled", 32'(rc), 2);
        // R6 enable and DATA
        step(1, 32'h8000_0000, 0, 0, 1, 0, 0, 0);
        check(txe, "R6 enable set", 32'(txe), 1);
        step(1, 32'h0000_0000, 1, 0, 1, 0, 0, 0);
        check(txe && rv && rc == 2'd1, "R6 R5 data", 32'(rc), 1);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        check(rc == 2'd2, "R5 empty fifo", 32'(rc), 2);
        step(0, 0, 1, 0, 1, 0, 1, 0);
        check(rc == 2'd2, "R5 global np nak", 32'(rc), 2);
        step(0, 0, 1, 0, 1, 0, 0, 1);
        check(rc == 2'd2, "R5 global out nak", 32'(rc), 2);
        step(1, 32'h0800_0000, 0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0, 0, 0);
        check(rc == 2'd2, "R5 local nak full fifo", 32'(rc), 2);

        // R4 stall
        step(1, 32'h0020_0000, 0, 0, 1, 0, 0, 0);
        check(rd[21], "R4 stall set", rd, 32'h0020_0000);
        step(1, 32'h0000_0000, 0, 0, 1, 0, 0, 0);
        check(rd[21], "R4 write zero keeps", rd, 32'h0020_0000);
        step(0, 0, 1, 0, 1, 0, 1, 1);
        check(rc == 2'd3, "R5 stall wins", 32'(rc), 3);

        // R3 setup with stall write and token
        step(1, 32'h0420_0000, 1, 1, 1, 0, 0, 0);
        check(rv && rc == 2'd0, "R3 ack", 32'(rc), 0);
        check(!rd[21] && rd[17], "R3 stall cleared nak set", rd, 32'h0002_8000);

        // R8 transfer done
        step(1, 32'h0400_0000, 0, 0, 1, 1, 0, 0);
        check(!txe, "R8 enable cleared", 32'(txe), 0);
        check(!idone, "R8 not yet", 32'(idone), 0);
        idle(1);
        check(idone, "R8 pulse", 32'(idone), 1);
        idle(1);
        check(!idone, "R8 single cycle", 32'(idone), 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        idle(2);

        // R7 disable ignored then honoured
        step(1, 32'h4000_0000, 0, 0, 0, 0, 0, 0);
        check(!rd[30], "R7 ignored when off", rd, 32'h0000_8000);
        step(1, 32'h8000_0000, 0, 0, 0, 0, 0, 0);
        step(1, 32'h4000_0000, 0, 0, 0, 0, 0, 0);
        check(rd[30] && rd[31], "R7 pending", rd, 32'hC000_8000);
        idle(1);
        check(!rd[30] && !txe, "R7 cleared", rd, 32'h0000_8000);
        idle(1);
        check(idis, "R7 pulse", 32'(idis), 1);
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule